// File: doc/BRIEF.md
# Hot-Plug Slot Power Sequencer

This block controls the power-up and power-down of as many as six hot-plug expansion slots. Software writes a wanted slot pattern into an enable register. That write changes nothing at the slots by itself. A separate write to a control register commits the pattern. The block then compares the committed pattern with the pattern last applied. Slots that are being removed go through a four-step shutdown, and after that the slots that are being added go through a four-step bring-up.

Each slot has four outputs: power enable (active high), clock enable (active low), bus enable (active low) and reset (active low). Power-on straps mark which slots are populated, and a switch input per slot reports an open retention latch. Both of these gate what software may store. A programmable gap in clock cycles separates the steps of a sequence. A busy flag and a self-clearing commit bit report progress. A commit written while a sequence is running is kept and runs when the current one ends.

Top module: `slot_pwr_seq`

## Requirements
- R1: After reset every slot is off (power enable 0, clock enable 1, bus enable 1, reset 0), busy is 0, and both registers read 00h.
- R2: Address 0 is the enable register. Bit 0 is the first slot and bit 5 is the sixth slot. Bits 7:6 always read 0. Address 1 is the control register. Writing it with bit 0 set commits. On read, bit 0 is the commit bit, bit 1 is busy, and all other bits are 0. Read data appears one cycle after the read address is presented.
- R3: A write to an enable bit whose strap marks the slot as absent leaves that bit unchanged.
- R4: While a slot's switch input is high (open), a write of 1 to its enable bit is ignored. A write of 0 is still accepted.
- R5: Writing the enable register changes no slot output and does not set busy. Reading the register returns the stored pattern.
- R6: For each slot that the commit adds, the bring-up order is: power enable rises, then clock enable falls, then bus enable falls, then reset rises. The first step takes effect two clock edges after the commit write edge. Successive steps are gap+1 cycles apart.
- R7: For each slot that the commit removes, the shutdown runs in the exact reverse order: reset falls, bus enable rises, clock enable rises, power enable falls. The spacing is the same as in R6.
- R8: When one commit both removes and adds slots, all four shutdown steps finish first. The first bring-up step follows the last shutdown step by gap+1 cycles.
- R9: Busy rises one edge after the commit write. It falls on the edge that applies the final step. The commit bit reads 1 from the commit write until that edge and then clears by itself.
- R10: A commit written while busy is held. It starts a new sequence, using the enable register contents at that time, on the edge after the running sequence ends. This also holds when the write lands on that final edge.
- R11: A commit whose pattern equals the applied pattern changes no output, never raises busy, and clears the commit bit.
- R12: Slot outputs change only while busy, or on the edge where busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 enable, 1 control |
| wr_data | input | REG_W | Write data |
| rd_addr | input | 1 | Read address: 0 enable, 1 control |
| rd_data | output | REG_W | Registered read data |
| strap_present | input | NUM_SLOTS | Power-on strap, 1 = slot populated |
| switch_open | input | NUM_SLOTS | Retention switch, 1 = open |
| cfg_gap | input | GAP_W | Idle cycles between sequence steps |
| slot_pwr_en | output | NUM_SLOTS | Slot power enable, active high |
| slot_clk_en_n | output | NUM_SLOTS | Slot clock enable, active low |
| slot_bus_en_n | output | NUM_SLOTS | Slot bus enable, active low |
| slot_rst_n | output | NUM_SLOTS | Slot reset, active low |
| busy | output | 1 | Sequence in progress |

## Verification
Two events can fall in the same cycle: the edge where a running sequence applies its final step and clears busy, and a commit write from software. The bench provokes this by counting cycles from the first commit and placing the second commit write on that final edge, with a further slot already staged in the enable register. The check passes only if busy reads 0 for exactly that one cycle, rises again on the next edge, and the staged slot then comes up on schedule while the first slot stays fully on.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  localparam logic ADDR_EN   = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int   STEPS     = 4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_DOWN = 2'd1,
    SQ_UP   = 2'd2
  } sq_state_e;

  typedef logic [1:0] step_t;
endpackage

// File: rtl/slot_en_reg.sv
module slot_en_reg
  import slot_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [NUM_SLOTS-1:0] wr_bits,
  input  logic [NUM_SLOTS-1:0] strap_present,
  input  logic [NUM_SLOTS-1:0] switch_open,
  output logic [NUM_SLOTS-1:0] en_q
);
  logic hit;
  assign hit = wr_en && (wr_addr == ADDR_EN);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
    logic allow;
    // absent slots are frozen; an open latch blocks only a set
    assign allow = strap_present[i] && !(wr_bits[i] && switch_open[i]);
    always_ff @(posedge clk) begin
      if (rst) en_q[i] <= 1'b0;
      else if (hit && allow) en_q[i] <= wr_bits[i];
    end
  end
endmodule

// File: rtl/slot_seq_ctrl.sv
module slot_seq_ctrl
  import slot_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int GAP_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 commit_wr,
  input  logic [NUM_SLOTS-1:0] target,
  input  logic [GAP_W-1:0]     cfg_gap,
  output logic                 busy,
  output logic                 commit_bit,
  output logic                 fire,
  output logic                 going_down,
  output step_t                step,
  output logic [NUM_SLOTS-1:0] rm_mask,
  output logic [NUM_SLOTS-1:0] add_mask
);
  localparam step_t LAST_STEP = step_t'(STEPS - 1);

  sq_state_e              state;
  logic [GAP_W-1:0]       cnt, gap_q;
  logic                   go_req;
  logic [NUM_SLOTS-1:0]   applied;
  logic [NUM_SLOTS-1:0]   rm_next, add_next;

  assign rm_next    = applied & ~target;
  assign add_next   = target & ~applied;
  assign fire       = (state != SQ_IDLE) && (cnt == '0);
  assign going_down = (state == SQ_DOWN);
  assign commit_bit = go_req | busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      step     <= '0;
      cnt      <= '0;
      gap_q    <= '0;
      go_req   <= 1'b0;
      applied  <= '0;
      rm_mask  <= '0;
      add_mask <= '0;
      busy     <= 1'b0;
    end else begin
      // a new commit always wins over consumption of the old one
      go_req <= commit_wr | (go_req & (state != SQ_IDLE));
      case (state)
        SQ_IDLE: begin
          if (go_req) begin
            rm_mask  <= rm_next;
            add_mask <= add_next;
            applied  <= target;
            gap_q    <= cfg_gap;
            step     <= '0;
            cnt      <= '0;
            if (rm_next != '0) begin
              state <= SQ_DOWN;
              busy  <= 1'b1;
            end else if (add_next != '0) begin
              state <= SQ_UP;
              busy  <= 1'b1;
            end
          end
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cnt <= gap_q;
            if (step == LAST_STEP) begin
              step <= '0;
              if (state == SQ_DOWN && add_mask != '0) begin
                state <= SQ_UP;
              end else begin
                state <= SQ_IDLE;
                busy  <= 1'b0;
              end
            end else begin
              step <= step + 2'd1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/slot_out_drv.sv
module slot_out_drv
  import slot_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic                 going_down,
  input  step_t                step,
  input  logic [NUM_SLOTS-1:0] rm_mask,
  input  logic [NUM_SLOTS-1:0] add_mask,
  output logic [NUM_SLOTS-1:0] pwr_en,
  output logic [NUM_SLOTS-1:0] clk_en_n,
  output logic [NUM_SLOTS-1:0] bus_en_n,
  output logic [NUM_SLOTS-1:0] rst_n
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic sel;
    assign sel = fire && (going_down ? rm_mask[i] : add_mask[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        pwr_en[i]   <= 1'b0;
        clk_en_n[i] <= 1'b1;
        bus_en_n[i] <= 1'b1;
        rst_n[i]    <= 1'b0;
      end else if (sel) begin
        // shutdown walks the bring-up order backwards
        case (step)
          2'd0: if (going_down) rst_n[i] <= 1'b0;    else pwr_en[i]   <= 1'b1;
          2'd1: if (going_down) bus_en_n[i] <= 1'b1; else clk_en_n[i] <= 1'b0;
          2'd2: if (going_down) clk_en_n[i] <= 1'b1; else bus_en_n[i] <= 1'b0;
          default: if (going_down) pwr_en[i] <= 1'b0; else rst_n[i]  <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
  import slot_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int REG_W     = 8,
  parameter int GAP_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  input  logic                 rd_addr,
  output logic [REG_W-1:0]     rd_data,
  input  logic [NUM_SLOTS-1:0] strap_present,
  input  logic [NUM_SLOTS-1:0] switch_open,
  input  logic [GAP_W-1:0]     cfg_gap,
  output logic [NUM_SLOTS-1:0] slot_pwr_en,
  output logic [NUM_SLOTS-1:0] slot_clk_en_n,
  output logic [NUM_SLOTS-1:0] slot_bus_en_n,
  output logic [NUM_SLOTS-1:0] slot_rst_n,
  output logic                 busy
);
  logic [NUM_SLOTS-1:0] en_q, rm_mask, add_mask;
  logic                 commit_wr, commit_bit, fire, going_down;
  step_t                step;
  logic [REG_W-1:0]     en_view, ctrl_view;
  logic                 unused_wr_hi;

  assign unused_wr_hi = ^wr_data;
  assign commit_wr    = wr_en && (wr_addr == ADDR_CTRL) && wr_data[0];

  slot_en_reg #(.NUM_SLOTS(NUM_SLOTS)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[NUM_SLOTS-1:0]), .strap_present(strap_present),
    .switch_open(switch_open), .en_q(en_q)
  );

  slot_seq_ctrl #(.NUM_SLOTS(NUM_SLOTS), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rst(rst), .commit_wr(commit_wr), .target(en_q),
    .cfg_gap(cfg_gap), .busy(busy), .commit_bit(commit_bit), .fire(fire),
    .going_down(going_down), .step(step), .rm_mask(rm_mask), .add_mask(add_mask)
  );

  slot_out_drv #(.NUM_SLOTS(NUM_SLOTS)) u_drv (
    .clk(clk), .rst(rst), .fire(fire), .going_down(going_down), .step(step),
    .rm_mask(rm_mask), .add_mask(add_mask), .pwr_en(slot_pwr_en),
    .clk_en_n(slot_clk_en_n), .bus_en_n(slot_bus_en_n), .rst_n(slot_rst_n)
  );

  always_comb begin
    en_view                  = '0;
    en_view[NUM_SLOTS-1:0]   = en_q;
    ctrl_view                = '0;
    ctrl_view[0]             = commit_bit;
    ctrl_view[1]             = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= (rd_addr == ADDR_CTRL) ? ctrl_view : en_view;
  end
endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk #(
  parameter int NUM_SLOTS = 6,
  parameter int REG_W     = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_addr,
  input logic [REG_W-1:0]     rd_data,
  input logic [NUM_SLOTS-1:0] slot_pwr_en,
  input logic [NUM_SLOTS-1:0] slot_clk_en_n,
  input logic [NUM_SLOTS-1:0] slot_bus_en_n,
  input logic [NUM_SLOTS-1:0] slot_rst_n,
  input logic                 busy
);
  // R6/R7: a slot's clock is on only while powered
  a_r6_clock_needs_power: assert property (@(posedge clk) disable iff (rst)
    ((~slot_clk_en_n & ~slot_pwr_en) == '0));

  // R6/R7: bus enabled only while clock enabled
  a_r7_bus_needs_clock: assert property (@(posedge clk) disable iff (rst)
    ((~slot_bus_en_n & slot_clk_en_n) == '0));

  // R6/R7: reset released only while bus enabled
  a_r6_reset_needs_bus: assert property (@(posedge clk) disable iff (rst)
    ((slot_rst_n & slot_bus_en_n) == '0));

  // R8: power never rises while another slot is part way through its sequence
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    ((slot_pwr_en & ~$past(slot_pwr_en)) != '0) |->
      ((slot_pwr_en & $past(slot_pwr_en) & ~slot_rst_n) == '0));

  // R12: outputs hold while the sequencer is idle
  a_r12_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |->
      ($stable(slot_pwr_en) && $stable(slot_clk_en_n) &&
       $stable(slot_bus_en_n) && $stable(slot_rst_n)));

  // R2: reserved enable bits read as zero
  if (REG_W > NUM_SLOTS) begin : g_rsv
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      !$past(rd_addr) |-> (rd_data[REG_W-1:NUM_SLOTS] == '0));
  end
endmodule

bind slot_pwr_seq slot_pwr_seq_chk #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
  .slot_pwr_en(slot_pwr_en), .slot_clk_en_n(slot_clk_en_n),
  .slot_bus_en_n(slot_bus_en_n), .slot_rst_n(slot_rst_n), .busy(busy)
);

// File: tb/slot_pwr_seq_test.sv
module slot_pwr_seq_test;
  localparam int NS = 6;
  localparam int RW = 8;
  localparam int GW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [RW-1:0] wr_data = '0;
  logic [RW-1:0] rd_data;
  logic [NS-1:0] strap_present = '1, switch_open = '0;
  logic [GW-1:0] cfg_gap = 8'd3;
  logic [NS-1:0] pwr, clk_n, bus_n, rst_n;
  logic          busy;

  int total = 0, bad = 0, gap = 3;
  int exp_lvl [NS];

  always #5 clk = ~clk;

  slot_pwr_seq #(.NUM_SLOTS(NS), .REG_W(RW), .GAP_W(GW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .strap_present(strap_present),
    .switch_open(switch_open), .cfg_gap(cfg_gap), .slot_pwr_en(pwr),
    .slot_clk_en_n(clk_n), .slot_bus_en_n(bus_n), .slot_rst_n(rst_n), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  function automatic logic [3:0] tuple_of(input int lvl);
    case (lvl)
      0: return 4'b0110;
      1: return 4'b1110;
      2: return 4'b1010;
      3: return 4'b1000;
      default: return 4'b1001;
    endcase
  endfunction

  task automatic check_slots(input string tag);
    for (int i = 0; i < NS; i++) begin
      logic [3:0] got;
      got = {pwr[i], clk_n[i], bus_n[i], rst_n[i]};
      chk(got == tuple_of(exp_lvl[i]), tag, got, tuple_of(exp_lvl[i]));
    end
  endtask

  task automatic write_reg(input logic a, input logic [RW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic a, output logic [RW-1:0] d);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  // called at the negedge after the commit write edge
  task automatic run_seq(input logic [NS-1:0] rm, input logic [NS-1:0] add, input string tag);
    bit first = 1;
    step(1);
    chk(busy == 1'b1, {tag, " R9 busy rise"}, busy, 1);
    check_slots({tag, " R6 no early change"});
    for (int half = 0; half < 2; half++) begin
      logic [NS-1:0] m;
      m = (half == 0) ? rm : add;
      if (m != '0) begin
        for (int k = 0; k < 4; k++) begin
          if (!first) begin
            step(gap);
            check_slots({tag, " R6 R7 gap hold"});
            chk(busy == 1'b1, {tag, " R9 busy hold"}, busy, 1);
            step(1);
          end else begin
            step(1);
          end
          first = 0;
          for (int i = 0; i < NS; i++)
            if (m[i]) exp_lvl[i] = (half == 0) ? 3 - k : k + 1;
          check_slots(half == 0 ? {tag, " R7 R8 down step"} : {tag, " R6 R8 up step"});
          if (k == 3 && (half == 1 || add == '0))
            chk(busy == 1'b0, {tag, " R9 busy fall"}, busy, 0);
          else
            chk(busy == 1'b1, {tag, " R9 busy mid"}, busy, 1);
        end
      end
    end
  endtask

  task automatic t_reset;
    logic [RW-1:0] d;
    check_slots("R1 reset outputs");
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    read_reg(1'b0, d); chk(d == 8'h00, "R1 enable reg", d, 8'h00);
    read_reg(1'b1, d); chk(d == 8'h00, "R1 control reg", d, 8'h00);
  endtask

  task automatic t_protect;
    logic [RW-1:0] d;
    strap_present = 6'b011111; switch_open = 6'b000100;
    write_reg(1'b0, 8'hFF);
    read_reg(1'b0, d); chk(d == 8'h1B, "R2 R3 R4 masked write", d, 8'h1B);
    step(3);
    check_slots("R5 write alone");
    chk(busy == 1'b0, "R5 no busy", busy, 0);
    switch_open = '0;
    write_reg(1'b0, 8'h04);
    read_reg(1'b0, d); chk(d == 8'h04, "R5 readback", d, 8'h04);
    switch_open = 6'b000100;
    write_reg(1'b0, 8'h00);
    read_reg(1'b0, d); chk(d == 8'h00, "R4 clear while open", d, 8'h00);
    write_reg(1'b0, 8'h04);
    read_reg(1'b0, d); chk(d == 8'h00, "R4 set blocked", d, 8'h00);
    switch_open = '0; strap_present = '1;
  endtask

  task automatic t_enable;
    logic [RW-1:0] d;
    write_reg(1'b0, 8'h03);
    write_reg(1'b1, 8'h01);
    run_seq('0, 6'h03, "enable");
    read_reg(1'b1, d); chk(d == 8'h00, "R9 commit cleared", d, 8'h00);
  endtask

  task automatic t_disable;
    write_reg(1'b0, 8'h01);
    write_reg(1'b1, 8'h01);
    run_seq(6'h02, '0, "disable");
  endtask

  task automatic t_mixed;
    write_reg(1'b0, 8'h04);
    write_reg(1'b1, 8'h01);
    run_seq(6'h01, 6'h04, "mixed");
  endtask

  task automatic t_same_cycle;
    write_reg(1'b0, 8'h0C);
    write_reg(1'b1, 8'h01);
    write_reg(1'b0, 8'h1C);
    step(3 * gap + 3);
    write_reg(1'b1, 8'h01);
    exp_lvl[3] = 4;
    check_slots("R10 first run done");
    chk(busy == 1'b0, "R10 idle gap", busy, 0);
    run_seq('0, 6'h10, "R10 pending");
  endtask

  task automatic t_fast_and_noop;
    logic [RW-1:0] d;
    gap = 0; cfg_gap = 8'd0;
    write_reg(1'b0, 8'h00);
    write_reg(1'b1, 8'h01);
    run_seq(6'h1C, '0, "gap0 off");
    write_reg(1'b0, 8'h01);
    write_reg(1'b1, 8'h01);
    read_reg(1'b1, d); chk(d[0] == 1'b1, "R9 commit bit set", d[0], 1);
    for (int w = 0; w < 40 && busy; w++) step(1);
    exp_lvl[0] = 4;
    check_slots("R6 gap0 on");
    read_reg(1'b1, d); chk(d == 8'h00, "R9 commit self-clear", d, 8'h00);
    write_reg(1'b1, 8'h01);
    for (int k = 0; k < 4; k++) begin
      chk(busy == 1'b0, "R11 no busy", busy, 0);
      step(1);
    end
    check_slots("R11 unchanged");
    read_reg(1'b1, d); chk(d == 8'h00, "R11 commit cleared", d, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) exp_lvl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_protect();
    t_enable();
    t_disable();
    t_mixed();
    t_same_cycle();
    t_fast_and_noop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule